// File: doc/BRIEF.md
# Compressed Instruction Expander

This purely combinational block sits between instruction fetch and decode in a 32-bit RISC-V core. It takes one 32-bit fetched word and decides from its two lowest bits whether the word is a full-width base instruction or a 16-bit compressed one. A base instruction passes through unchanged. A compressed instruction from the supported subset is rewritten as the equivalent base-ISA word, so the downstream decoder only ever sees 32-bit encodings.

Alongside the rewritten word, the block reports the length class of the instruction and the amount the program counter advances when no control transfer takes place: 2 for compressed, 4 for base. The fetch stage uses this for the fall-through address. The execute stage uses it for the link value of jumps, so a compressed jump-and-link saves PC+2.

The supported subset covers stack-pointer arithmetic, word loads and stores (register-based and stack-based), immediate add and load-immediate, jumps with and without link, zero-compare branches, register jump and register move. Any other compressed encoding, and any reserved form within the subset, raises an illegal flag and produces a no-operation word.

Top module: `rvc_expander`

## Requirements
- R1: A word with bits [1:0] = 2'b11 is reported as base (`compressed_o` = 0, `pc_step_o` = 4). Any other value of bits [1:0] is reported as compressed (`compressed_o` = 1, `pc_step_o` = 2).
- R2: A base word appears unchanged on `expanded_o`, with `illegal_o` = 0.
- R3: A 3-bit compressed register field f names register x(8+f). Every expanded word has bits [1:0] = 2'b11.
- R4: Quadrant 0, funct3 000 (stack-pointer add to rd') expands to ADDI rd', x2, uimm. Here uimm = {h[10:7], h[12:11], h[5], h[6], 2'b00}, zero-extended, and rd' is field h[4:2]. A uimm of zero is illegal.
- R5: Quadrant 0, funct3 010 and 110 expand to LW rd', off(rs1') and SW rs2', off(rs1'). The offset is {h[5], h[12:10], h[6], 2'b00}, rs1' is h[9:7], and rd'/rs2' is h[4:2].
- R6: Quadrant 1, funct3 000 expands to ADDI rd, rd, imm. Quadrant 1, funct3 010 expands to ADDI rd, x0, imm. In both, imm = sext({h[12], h[6:2]}) and rd = h[11:7].
- R7: Quadrant 1, funct3 011 with rd = 2 expands to ADDI x2, x2, imm. Here imm = sext({h[12], h[4:3], h[5], h[2], h[6], 4'b0000}). A zero immediate is illegal, and so is rd != 2 in this slot.
- R8: Quadrant 1, funct3 001 expands to JAL x1, off, and funct3 101 expands to JAL x0, off. Here off = sext({h[12], h[8], h[10:9], h[6], h[7], h[2], h[11], h[5:3], 1'b0}).
- R9: Quadrant 1, funct3 110 and 111 expand to BEQ and BNE rs1', x0, off. Here off = sext({h[12], h[6:5], h[2], h[11:10], h[4:3], 1'b0}) and rs1' is h[9:7].
- R10: Quadrant 2, funct3 010 expands to LW rd, off(x2). Here off = {h[3:2], h[12], h[6:4], 2'b00}, and rd = 0 is illegal. Quadrant 2, funct3 110 expands to SW rs2, off(x2). Here off = {h[8:7], h[12:9], 2'b00} and rs2 = h[6:2].
- R11: Quadrant 2, funct3 100 with h[12] = 0 expands in one of two ways. If h[6:2] = 0, it becomes JALR x0, 0(rs1) with rs1 = h[11:7], and rs1 = 0 is illegal. Otherwise it becomes ADD rd, x0, rs2 with rd = h[11:7] and rs2 = h[6:2].
- R12: Every other compressed encoding, including the all-zero halfword, sets `illegal_o` = 1 and outputs 32'h0000_0013. For compressed words, bits [31:16] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_word_i | input | 32 | Fetched word; a compressed instruction occupies bits [15:0] |
| expanded_o | output | 32 | Base-ISA instruction handed to decode |
| compressed_o | output | 1 | High when the input is a 16-bit instruction |
| pc_step_o | output | 3 | Sequential PC increment, 2 or 4 |
| illegal_o | output | 1 | High for an unsupported or reserved compressed encoding |

## Verification
The awkward cases are the reserved forms hidden inside legal opcodes. These include a stack-pointer add whose scattered immediate bits are all zero, a stack load or register jump naming x0, and the load-upper slot that shares funct3 with the stack adjust. Only particular bit combinations reach them, and a compressed word carrying stale upper-half bits must be shown not to disturb the result. The bench therefore sweeps all 65,536 low halfwords, each paired with an upper half that changes from one step to the next. That visits every reserved corner and every immediate bit position. The expected value for each step is rebuilt by adding the weight of each immediate bit.

// File: rtl/rvc_xlat_pkg.sv
package rvc_xlat_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned REG_W   = 5;
    localparam int unsigned CREG_W  = 3;
    localparam int unsigned STEP_W  = 3;

    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_REG    = 7'b0110011;

    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_WORD = 3'b010;

    localparam logic [REG_W-1:0] X_ZERO = 5'd0;
    localparam logic [REG_W-1:0] X_RA   = 5'd1;
    localparam logic [REG_W-1:0] X_SP   = 5'd2;

    localparam logic [WORD_W-1:0] NOP_WORD = 32'h0000_0013;

    localparam logic [STEP_W-1:0] STEP_HALF = 3'd2;
    localparam logic [STEP_W-1:0] STEP_FULL = 3'd4;

    typedef enum logic [1:0] {
        QD_ZERO = 2'b00,
        QD_ONE  = 2'b01,
        QD_TWO  = 2'b10,
        QD_BASE = 2'b11
    } quadrant_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              bad;
    } xlat_t;

    localparam xlat_t XLAT_BAD = '{word: NOP_WORD, bad: 1'b1};

    function automatic logic [REG_W-1:0] creg(input logic [CREG_W-1:0] f);
        return {2'b01, f};
    endfunction

    function automatic logic [WORD_W-1:0] enc_i(input logic [11:0] imm,
                                                input logic [REG_W-1:0] rs1,
                                                input logic [2:0] f3,
                                                input logic [REG_W-1:0] rd,
                                                input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [WORD_W-1:0] enc_s(input logic [11:0] imm,
                                                input logic [REG_W-1:0] rs2,
                                                input logic [REG_W-1:0] rs1,
                                                input logic [2:0] f3,
                                                input logic [6:0] op);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
    endfunction

    function automatic logic [WORD_W-1:0] enc_b(input logic [12:0] imm,
                                                input logic [REG_W-1:0] rs2,
                                                input logic [REG_W-1:0] rs1,
                                                input logic [2:0] f3);
        return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
    endfunction

    function automatic logic [WORD_W-1:0] enc_j(input logic [20:0] imm,
                                                input logic [REG_W-1:0] rd);
        return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
    endfunction

    function automatic logic [WORD_W-1:0] enc_r(input logic [REG_W-1:0] rs2,
                                                input logic [REG_W-1:0] rs1,
                                                input logic [REG_W-1:0] rd);
        return {7'b0000000, rs2, rs1, F3_ADD, rd, OPC_REG};
    endfunction

    function automatic xlat_t ok(input logic [WORD_W-1:0] w);
        return '{word: w, bad: 1'b0};
    endfunction

endpackage

// File: rtl/rvc_len_detect.sv
module rvc_len_detect
    import rvc_xlat_pkg::*;
(
    input  logic [1:0]        low_bits_i,
    output logic              is_half_o,
    output logic [STEP_W-1:0] step_o
);
    always_comb begin
        is_half_o = (low_bits_i != QD_BASE);
        step_o    = is_half_o ? STEP_HALF : STEP_FULL;
    end
endmodule

// File: rtl/rvc_q0_dec.sv
module rvc_q0_dec
    import rvc_xlat_pkg::*;
(
    input  logic [HALF_W-1:0] half_i,
    output xlat_t             res_o
);
    logic [9:0] sp_uimm;
    logic [6:0] word_off;
    logic [REG_W-1:0] rlow, rmid;

    always_comb begin
        sp_uimm  = {half_i[10:7], half_i[12:11], half_i[5], half_i[6], 2'b00};
        word_off = {half_i[5], half_i[12:10], half_i[6], 2'b00};
        rlow     = creg(half_i[4:2]);
        rmid     = creg(half_i[9:7]);
        res_o    = XLAT_BAD;
        unique case (half_i[15:13])
            3'b000: if (sp_uimm != '0)
                        res_o = ok(enc_i({2'b00, sp_uimm}, X_SP, F3_ADD, rlow, OPC_IMM));
            3'b010: res_o = ok(enc_i({5'b0, word_off}, rmid, F3_WORD, rlow, OPC_LOAD));
            3'b110: res_o = ok(enc_s({5'b0, word_off}, rlow, rmid, F3_WORD, OPC_STORE));
            default: res_o = XLAT_BAD;
        endcase
    end
endmodule

// File: rtl/rvc_q1_dec.sv
module rvc_q1_dec
    import rvc_xlat_pkg::*;
(
    input  logic [HALF_W-1:0] half_i,
    output xlat_t             res_o
);
    logic [11:0] imm6_sx;
    logic [11:0] jmp_off;
    logic [9:0]  sp16;
    logic [8:0]  br_off;
    logic [REG_W-1:0] rd;

    always_comb begin
        rd      = half_i[11:7];
        imm6_sx = {{6{half_i[12]}}, half_i[12], half_i[6:2]};
        jmp_off = {half_i[12], half_i[8], half_i[10:9], half_i[6], half_i[7],
                   half_i[2], half_i[11], half_i[5:3], 1'b0};
        sp16    = {half_i[12], half_i[4:3], half_i[5], half_i[2], half_i[6], 4'b0000};
        br_off  = {half_i[12], half_i[6:5], half_i[2], half_i[11:10], half_i[4:3], 1'b0};
        res_o   = XLAT_BAD;
        unique case (half_i[15:13])
            3'b000: res_o = ok(enc_i(imm6_sx, rd, F3_ADD, rd, OPC_IMM));
            3'b001: res_o = ok(enc_j({{9{jmp_off[11]}}, jmp_off}, X_RA));
            3'b010: res_o = ok(enc_i(imm6_sx, X_ZERO, F3_ADD, rd, OPC_IMM));
            3'b011: if (rd == X_SP && sp16 != '0)
                        res_o = ok(enc_i({{2{sp16[9]}}, sp16}, X_SP, F3_ADD, X_SP, OPC_IMM));
            3'b101: res_o = ok(enc_j({{9{jmp_off[11]}}, jmp_off}, X_ZERO));
            3'b110,
            3'b111: res_o = ok(enc_b({{4{br_off[8]}}, br_off}, X_ZERO,
                                     creg(half_i[9:7]), {2'b00, half_i[13]}));
            default: res_o = XLAT_BAD;
        endcase
    end
endmodule

// File: rtl/rvc_q2_dec.sv
module rvc_q2_dec
    import rvc_xlat_pkg::*;
(
    input  logic [HALF_W-1:0] half_i,
    output xlat_t             res_o
);
    logic [7:0] ld_off, st_off;
    logic [REG_W-1:0] rd, rs2;

    always_comb begin
        rd     = half_i[11:7];
        rs2    = half_i[6:2];
        ld_off = {half_i[3:2], half_i[12], half_i[6:4], 2'b00};
        st_off = {half_i[8:7], half_i[12:9], 2'b00};
        res_o  = XLAT_BAD;
        unique case (half_i[15:13])
            3'b010: if (rd != X_ZERO)
                        res_o = ok(enc_i({4'b0, ld_off}, X_SP, F3_WORD, rd, OPC_LOAD));
            3'b100: begin
                if (!half_i[12]) begin
                    if (rs2 != X_ZERO)
                        res_o = ok(enc_r(rs2, X_ZERO, rd));
                    else if (rd != X_ZERO)
                        res_o = ok(enc_i(12'd0, rd, F3_ADD, X_ZERO, OPC_JALR));
                end
            end
            3'b110: res_o = ok(enc_s({4'b0, st_off}, rs2, X_SP, F3_WORD, OPC_STORE));
            default: res_o = XLAT_BAD;
        endcase
    end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
    import rvc_xlat_pkg::*;
(
    input  logic [WORD_W-1:0] fetch_word_i,
    output logic [WORD_W-1:0] expanded_o,
    output logic              compressed_o,
    output logic [STEP_W-1:0] pc_step_o,
    output logic              illegal_o
);
    logic [HALF_W-1:0] half;
    xlat_t q0_res, q1_res, q2_res, sel;

    assign half = fetch_word_i[HALF_W-1:0];

    rvc_len_detect u_len (
        .low_bits_i (fetch_word_i[1:0]),
        .is_half_o  (compressed_o),
        .step_o     (pc_step_o)
    );

    rvc_q0_dec u_q0 (.half_i(half), .res_o(q0_res));
    rvc_q1_dec u_q1 (.half_i(half), .res_o(q1_res));
    rvc_q2_dec u_q2 (.half_i(half), .res_o(q2_res));

    always_comb begin
        unique case (quadrant_e'(fetch_word_i[1:0]))
            QD_ZERO: sel = q0_res;
            QD_ONE:  sel = q1_res;
            QD_TWO:  sel = q2_res;
            default: sel = ok(fetch_word_i);
        endcase
        expanded_o = sel.word;
        illegal_o  = sel.bad;
    end
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk
    import rvc_xlat_pkg::*;
(
    input logic [WORD_W-1:0] fetch_word_i,
    input logic [WORD_W-1:0] expanded_o,
    input logic              compressed_o,
    input logic [STEP_W-1:0] pc_step_o,
    input logic              illegal_o
);
    always_comb begin
        if (!$isunknown(fetch_word_i)) begin
            assert_step_matches_len_R1: assert (pc_step_o == (compressed_o ? 3'd2 : 3'd4))
                else $error("step/length disagree");
            assert_base_passthrough_R2: assert (compressed_o || (expanded_o == fetch_word_i && !illegal_o))
                else $error("base word altered");
            assert_expanded_full_R3: assert (expanded_o[1:0] == 2'b11)
                else $error("expanded word not full width");
            assert_illegal_is_nop_R12: assert (!illegal_o || (compressed_o && expanded_o == NOP_WORD))
                else $error("illegal without nop");
            assert_jal_link_R8: assert (!(compressed_o && expanded_o[6:0] == OPC_JAL)
                                        || expanded_o[11:8] == 4'd0)
                else $error("compressed jal link not x0/x1");
            assert_jr_no_link_R11: assert (!(compressed_o && expanded_o[6:0] == OPC_JALR)
                                           || (expanded_o[11:7] == 5'd0 && expanded_o[31:20] == 12'd0))
                else $error("register jump links or offsets");
        end
    end
endmodule

bind rvc_expander rvc_expander_chk u_chk (
    .fetch_word_i (fetch_word_i),
    .expanded_o   (expanded_o),
    .compressed_o (compressed_o),
    .pc_step_o    (pc_step_o),
    .illegal_o    (illegal_o)
);

// File: tb/rvc_expander_bench.sv
module rvc_expander_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] fetch_word_i = 32'd0;
    logic [31:0] expanded_o;
    logic        compressed_o;
    logic [2:0]  pc_step_o;
    logic        illegal_o;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rvc_expander u_rvc_expander (
        .fetch_word_i (fetch_word_i),
        .expanded_o   (expanded_o),
        .compressed_o (compressed_o),
        .pc_step_o    (pc_step_o),
        .illegal_o    (illegal_o)
    );

    function automatic int b(input logic [15:0] h, input int k);
        return h[k] ? 1 : 0;
    endfunction

    function automatic int sx(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    function automatic logic [31:0] mk_i(input int imm, input int rs1, input int f3, input int rd, input int op);
        logic [31:0] iv, r1, f, d, o;
        iv = imm; r1 = rs1; f = f3; d = rd; o = op;
        return {iv[11:0], r1[4:0], f[2:0], d[4:0], o[6:0]};
    endfunction

    function automatic logic [31:0] mk_s(input int imm, input int rs2, input int rs1, input int op);
        logic [31:0] iv, r1, r2, o;
        iv = imm; r1 = rs1; r2 = rs2; o = op;
        return {iv[11:5], r2[4:0], r1[4:0], 3'b010, iv[4:0], o[6:0]};
    endfunction

    function automatic logic [31:0] mk_b(input int imm, input int rs1, input int f3);
        logic [31:0] iv, r1, f;
        iv = imm; r1 = rs1; f = f3;
        return {iv[12], iv[10:5], 5'd0, r1[4:0], f[2:0], iv[4:1], iv[11], 7'h63};
    endfunction

    function automatic logic [31:0] mk_j(input int imm, input int rd);
        logic [31:0] iv, d;
        iv = imm; d = rd;
        return {iv[20], iv[10:1], iv[11], iv[19:12], d[4:0], 7'h6F};
    endfunction

    task automatic ref_model(input logic [15:0] h, output logic [31:0] w, output logic bad, output string tag);
        int f, rd, rs2, p1, p2, v;
        f = int'(h[15:13]); rd = int'(h[11:7]); rs2 = int'(h[6:2]);
        p1 = 8 + int'(h[9:7]); p2 = 8 + int'(h[4:2]);
        w = 32'h13; bad = 1'b1; tag = "R12";
        case (h[1:0])
            2'b00: begin
                if (f == 0) begin
                    tag = "R4";
                    v = 4*b(h,6) + 8*b(h,5) + 16*b(h,11) + 32*b(h,12)
                      + 64*b(h,7) + 128*b(h,8) + 256*b(h,9) + 512*b(h,10);
                    if (v != 0) begin w = mk_i(v, 2, 0, p2, 'h13); bad = 1'b0; end
                end else if (f == 2 || f == 6) begin
                    tag = "R5";
                    v = 4*b(h,6) + 8*b(h,10) + 16*b(h,11) + 32*b(h,12) + 64*b(h,5);
                    w = (f == 2) ? mk_i(v, p1, 2, p2, 'h03) : mk_s(v, p2, p1, 'h23);
                    bad = 1'b0;
                end
            end
            2'b01: begin
                v = sx(b(h,2) + 2*b(h,3) + 4*b(h,4) + 8*b(h,5) + 16*b(h,6) + 32*b(h,12), 6);
                if (f == 0) begin tag = "R6"; w = mk_i(v, rd, 0, rd, 'h13); bad = 1'b0; end
                else if (f == 2) begin tag = "R6"; w = mk_i(v, 0, 0, rd, 'h13); bad = 1'b0; end
                else if (f == 1 || f == 5) begin
                    tag = "R8";
                    v = sx(2*b(h,3) + 4*b(h,4) + 8*b(h,5) + 16*b(h,11) + 32*b(h,2) + 64*b(h,7)
                         + 128*b(h,6) + 256*b(h,9) + 512*b(h,10) + 1024*b(h,8) + 2048*b(h,12), 12);
                    w = mk_j(v, (f == 1) ? 1 : 0); bad = 1'b0;
                end else if (f == 3) begin
                    tag = "R7";
                    v = sx(16*b(h,6) + 32*b(h,2) + 64*b(h,5) + 128*b(h,3) + 256*b(h,4) + 512*b(h,12), 10);
                    if (rd == 2 && v != 0) begin w = mk_i(v, 2, 0, 2, 'h13); bad = 1'b0; end
                end else if (f >= 6) begin
                    tag = "R9";
                    v = sx(2*b(h,3) + 4*b(h,4) + 8*b(h,10) + 16*b(h,11) + 32*b(h,2)
                         + 64*b(h,5) + 128*b(h,6) + 256*b(h,12), 9);
                    w = mk_b(v, p1, (f == 6) ? 0 : 1); bad = 1'b0;
                end
            end
            2'b10: begin
                if (f == 2) begin
                    tag = "R10";
                    v = 4*b(h,4) + 8*b(h,5) + 16*b(h,6) + 32*b(h,12) + 64*b(h,2) + 128*b(h,3);
                    if (rd != 0) begin w = mk_i(v, 2, 2, rd, 'h03); bad = 1'b0; end
                end else if (f == 6) begin
                    tag = "R10";
                    v = 4*b(h,9) + 8*b(h,10) + 16*b(h,11) + 32*b(h,12) + 64*b(h,7) + 128*b(h,8);
                    w = mk_s(v, rs2, 2, 'h23); bad = 1'b0;
                end else if (f == 4 && h[12] == 1'b0) begin
                    tag = "R11";
                    if (rs2 != 0) begin w = {7'd0, h[6:2], 5'd0, 3'd0, h[11:7], 7'h33}; bad = 1'b0; end
                    else if (rd != 0) begin w = mk_i(0, rd, 0, 0, 'h67); bad = 1'b0; end
                end
            end
            default: ;
        endcase
    endtask

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s word=%h actual=%h expected=%h", tag, fetch_word_i, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        fetch_word_i = w;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] ew;
        logic        eb;
        string       tg;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-time value: all-zero word is an illegal compressed encoding (R12)
        apply(32'd0);
        cmp("R12", {31'd0, illegal_o}, 32'd1);
        cmp("R12", expanded_o, 32'h13);
        // a few base words with every low pattern in the upper bits (R2, R1)
        for (int k = 0; k < 16; k++) begin
            logic [31:0] bw;
            bw = (32'h9E37_79B9 * (k + 1)) | 32'd3;
            apply(bw);
            cmp("R2", expanded_o, bw);
            cmp("R2", {31'd0, illegal_o}, 32'd0);
            cmp("R1", {29'd0, pc_step_o}, 32'd4);
        end
        // full halfword sweep, upper half varies per step (R3..R12)
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] h, up;
            h  = 16'(i);
            up = 16'(i * 40503) ^ 16'hA5C3;
            apply({up, h});
            if (h[1:0] == 2'b11) begin
                cmp("R2", expanded_o, {up, h});
                cmp("R1", {29'd0, pc_step_o, compressed_o}, {28'd0, 3'd4, 1'b0});
            end else begin
                ref_model(h, ew, eb, tg);
                cmp(tg, expanded_o, ew);
                cmp(tg, {31'd0, illegal_o}, {31'd0, eb});
                cmp("R1", {29'd0, pc_step_o, compressed_o}, {28'd0, 3'd2, 1'b1});
                if (!eb && ew[6:0] != 7'h63 && ew[6:0] != 7'h23 && ew[6:0] != 7'h6F && ew[6:0] != 7'h33) begin
                    // register-mapping spot check: destination field of I-type (R3)
                    if (h[1:0] == 2'b00) cmp("R3", {27'd0, expanded_o[11:7]}, {27'd0, 2'b01, h[4:2]});
                end
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule